// File: doc/BRIEF.md
# Data-driven macropixel readout controller

This block reads out a pixel matrix without any trigger. The matrix is cut into square macropixels. Every pixel keeps its own hit latch. Each macropixel reports a single OR of its latched pixels to the end-of-column unit that serves its column. On the first cycle that OR line is seen high, the end-of-column unit stores the current value of a free-running timestamp for that macropixel. From that point the macropixel is frozen: its pixels ignore new hits until its data has been handed off.

A token moves from column to column. It stops at any column that has pending macropixels and serves them from the lowest macropixel row upward. For each one it emits a word that carries the column index, the macropixel row, the stored timestamp and the pixel bitmap. A word is transferred only when valid and ready are both high. Only that transfer clears the pixel latches and the pending entry of the macropixel. When a column has nothing pending, the token moves on to the next column one cycle later and wraps after the last column.

Top module: `mpx_readout`

## Requirements
- R1: After reset, out_valid_o stays low, and no word appears until a pixel hit arrives.
- R2: A pixel at global row y and column x belongs to macropixel column x/MP and macropixel row y/MP. It sets bitmap bit (y mod MP)*MP + (x mod MP) in that macropixel's word. Hit input bit y*PIX_COLS + x carries that pixel.
- R3: The timestamp in a word is the ts_i value of the cycle after the cycle in which the hit was applied. That is the first cycle in which the macropixel's OR line is high. The value wraps modulo 2^TS_W.
- R4: Once a macropixel holds a hit, further hits on its pixels are dropped until its word is transferred. They change neither its bitmap nor the number of words.
- R5: All pixels of one macropixel that are hit in the same cycle appear together in a single word.
- R6: Within one column, pending macropixels are emitted in ascending row order.
- R7: The token serves one column until that column has nothing pending. It then moves to the next column in ascending order and wraps from the last column to column 0. In a burst, the words of one column are therefore contiguous.
- R8: While out_valid_o is high and out_ready_i is low, the word stays unchanged. Each hit macropixel produces exactly one word.
- R9: After its word is transferred, a macropixel accepts new hits and produces a new word with a new timestamp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | PIX_ROWS*PIX_COLS | Per-pixel hit bits, index row*PIX_COLS+col |
| ts_i | input | TS_W | Free-running timestamp counter |
| out_ready_i | input | 1 | Downstream accepts the word |
| out_valid_o | output | 1 | A word is present |
| out_col_o | output | CW | Macropixel column index |
| out_row_o | output | RW | Macropixel row index |
| out_ts_o | output | TS_W | Stored timestamp |
| out_map_o | output | MP*MP | Pixel bitmap, row-wise |

## Verification
The bench hits one pixel of an already pending macropixel while backpressure is applied. A design that did not freeze the macropixel would merge that pixel into the bitmap or emit an extra word. It places hits just before the timestamp wraps to check that the stored value is taken one cycle after the hit and wraps to 0. An off-by-one capture would show up as a shifted timestamp. Hits spread over several rows of one column and over all columns check the row priority and the column-by-column token. A token that left a column early, or a wrong priority encoder, would break the contiguous, ascending order of the words. A bursty ready pattern checks that every word is delivered exactly once and held stable while it is stalled.

// File: rtl/mpx_pkg.sv
package mpx_pkg;

   // index width that stays legal for a count of one
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/mpx_pixel_group.sv
module mpx_pixel_group #(
   parameter int MP       = 4,
   parameter int PIX_COLS = 32,
   parameter int PIX_ROWS = 8,
   parameter int MC       = 0,
   parameter int MR       = 0,
   localparam int NPIX    = PIX_COLS * PIX_ROWS,
   localparam int MPB     = MP * MP
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIX-1:0] hit_all_i,
   input  logic            clr_i,
   output logic [MPB-1:0]  map_o,
   output logic            or_o
);

   logic [MPB-1:0] loc_hit;
   logic [MPB-1:0] pix_q;
   logic           frozen;

   for (genvar lr = 0; lr < MP; lr++) begin : g_lr
      for (genvar lc = 0; lc < MP; lc++) begin : g_lc
         assign loc_hit[lr*MP+lc] = hit_all_i[(MR*MP+lr)*PIX_COLS + MC*MP + lc];
      end
   end

   assign frozen = |pix_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pix_q <= '0;
      else if (clr_i)   pix_q <= '0;
      else if (!frozen) pix_q <= loc_hit;
   end

   assign map_o = pix_q;
   assign or_o  = frozen;

   // R4: a holding group keeps its pattern until released
   p_frozen_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (or_o && !clr_i) |=> $stable(map_o));

endmodule

// File: rtl/mpx_eoc.sv
module mpx_eoc import mpx_pkg::*; #(
   parameter int NROW = 2,
   parameter int TS_W = 8,
   localparam int RW  = idx_w(NROW)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NROW-1:0] or_i,
   input  logic [NROW-1:0] clr_i,
   input  logic [TS_W-1:0] ts_i,
   output logic            any_o,
   output logic [RW-1:0]   sel_row_o,
   output logic [TS_W-1:0] sel_ts_o
);

   logic [NROW-1:0] pend_q;
   logic [TS_W-1:0] ts_q [NROW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         for (int r = 0; r < NROW; r++) ts_q[r] <= '0;
      end else begin
         for (int r = 0; r < NROW; r++) begin
            if (clr_i[r]) begin
               pend_q[r] <= 1'b0;
            end else if (or_i[r] && !pend_q[r]) begin
               pend_q[r] <= 1'b1;
               ts_q[r]   <= ts_i;
            end
         end
      end
   end

   // lowest pending row wins
   always_comb begin
      sel_row_o = '0;
      for (int r = NROW - 1; r >= 0; r--) begin
         if (pend_q[r]) sel_row_o = RW'(r);
      end
   end

   assign any_o    = |pend_q;
   assign sel_ts_o = ts_q[sel_row_o];

   for (genvar r = 0; r < NROW; r++) begin : g_chk
      // R8: an entry only leaves after its word was taken
      p_clear_acked_r8: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(pend_q[r]) |-> $past(clr_i[r]));
      // R3: the captured stamp does not drift while pending
      p_ts_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_q[r] && !clr_i[r]) |=> $stable(ts_q[r]));
   end

endmodule

// File: rtl/mpx_readout_ctrl.sv
module mpx_readout_ctrl import mpx_pkg::*; #(
   parameter int NCOL = 8,
   parameter int NROW = 2,
   parameter int TS_W = 8,
   parameter int MPB  = 16,
   localparam int CW  = idx_w(NCOL),
   localparam int RW  = idx_w(NROW)
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NCOL-1:0]                     col_any_i,
   input  logic [NCOL-1:0][RW-1:0]             col_row_i,
   input  logic [NCOL-1:0][TS_W-1:0]           col_ts_i,
   input  logic [NCOL-1:0][NROW-1:0][MPB-1:0]  map_all_i,
   input  logic                                ready_i,
   output logic                                valid_o,
   output logic [CW-1:0]                       col_o,
   output logic [RW-1:0]                       row_o,
   output logic [TS_W-1:0]                     ts_o,
   output logic [MPB-1:0]                      map_o,
   output logic [NCOL-1:0][NROW-1:0]           clr_o
);

   localparam logic [CW-1:0] LAST = CW'(NCOL - 1);

   logic [CW-1:0] tok_q;
   logic          fire;

   assign fire = valid_o && ready_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         tok_q   <= '0;
         col_o   <= '0;
         row_o   <= '0;
         ts_o    <= '0;
         map_o   <= '0;
      end else if (valid_o) begin
         if (ready_i) valid_o <= 1'b0;
      end else if (col_any_i[tok_q]) begin
         valid_o <= 1'b1;
         col_o   <= tok_q;
         row_o   <= col_row_i[tok_q];
         ts_o    <= col_ts_i[tok_q];
         map_o   <= map_all_i[tok_q][col_row_i[tok_q]];
      end else begin
         tok_q <= (tok_q == LAST) ? '0 : tok_q + 1'b1;
      end
   end

   always_comb begin
      clr_o = '0;
      if (fire) clr_o[col_o][row_o] = 1'b1;
   end

   // R8: a stalled word holds still
   p_hold_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i) |=> (valid_o && $stable(col_o) && $stable(row_o)
                                 && $stable(ts_o) && $stable(map_o)));
   // R7: a word is only raised for a column with a pending entry
   p_load_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_o) |-> col_any_i[col_o]);

endmodule

// File: rtl/mpx_readout.sv
module mpx_readout import mpx_pkg::*; #(
   parameter int MP       = 4,
   parameter int PIX_COLS = 32,
   parameter int PIX_ROWS = 8,
   parameter int TS_W     = 8,
   localparam int NCOL    = PIX_COLS / MP,
   localparam int NROW    = PIX_ROWS / MP,
   localparam int NPIX    = PIX_COLS * PIX_ROWS,
   localparam int MPB     = MP * MP,
   localparam int CW      = idx_w(NCOL),
   localparam int RW      = idx_w(NROW)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIX-1:0] hit_i,
   input  logic [TS_W-1:0] ts_i,
   input  logic            out_ready_i,
   output logic            out_valid_o,
   output logic [CW-1:0]   out_col_o,
   output logic [RW-1:0]   out_row_o,
   output logic [TS_W-1:0] out_ts_o,
   output logic [MPB-1:0]  out_map_o
);

   if (MP < 1 || PIX_COLS % MP != 0 || PIX_ROWS % MP != 0) begin : g_bad_geom
      $error("matrix dimensions must be multiples of the macropixel size");
   end
   if (TS_W < 1) begin : g_bad_ts
      $error("timestamp width must be at least one");
   end

   logic [NCOL-1:0][NROW-1:0][MPB-1:0] map_all;
   logic [NCOL-1:0][NROW-1:0]          mp_or;
   logic [NCOL-1:0][NROW-1:0]          mp_clr;
   logic [NCOL-1:0]                    col_any;
   logic [NCOL-1:0][RW-1:0]            col_row;
   logic [NCOL-1:0][TS_W-1:0]          col_ts;

   for (genvar c = 0; c < NCOL; c++) begin : g_col
      for (genvar r = 0; r < NROW; r++) begin : g_row
         mpx_pixel_group #(
            .MP(MP), .PIX_COLS(PIX_COLS), .PIX_ROWS(PIX_ROWS), .MC(c), .MR(r)
         ) u_grp (
            .clk(clk), .rst_n(rst_n), .hit_all_i(hit_i), .clr_i(mp_clr[c][r]),
            .map_o(map_all[c][r]), .or_o(mp_or[c][r])
         );
      end
      mpx_eoc #(.NROW(NROW), .TS_W(TS_W)) u_eoc (
         .clk(clk), .rst_n(rst_n), .or_i(mp_or[c]), .clr_i(mp_clr[c]),
         .ts_i(ts_i), .any_o(col_any[c]), .sel_row_o(col_row[c]),
         .sel_ts_o(col_ts[c])
      );
   end

   mpx_readout_ctrl #(
      .NCOL(NCOL), .NROW(NROW), .TS_W(TS_W), .MPB(MPB)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .col_any_i(col_any), .col_row_i(col_row),
      .col_ts_i(col_ts), .map_all_i(map_all), .ready_i(out_ready_i),
      .valid_o(out_valid_o), .col_o(out_col_o), .row_o(out_row_o),
      .ts_o(out_ts_o), .map_o(out_map_o), .clr_o(mp_clr)
   );

   // R2: every word carries at least one hit pixel
   p_map_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> (out_map_o != '0));

endmodule

// File: tb/mpx_readout_bench.sv
module mpx_readout_bench;
   localparam int MP = 2, PC = 8, PR = 8, TSW = 4;
   localparam int NCOL = PC / MP, NROW = PR / MP, NPIX = PC * PR, MPB = MP * MP;

   typedef struct { int c; int r; int ts; int map; } word_t;

   logic clk = 1'b0, rst_n = 1'b0, out_ready = 1'b0;
   logic [NPIX-1:0] hit = '0;
   logic [TSW-1:0]  ts;
   logic out_valid;
   logic [1:0] out_col, out_row;
   logic [TSW-1:0] out_ts;
   logic [MPB-1:0] out_map;
   int cyc = 0, checks = 0, errors = 0;
   word_t exp_q[$];
   word_t got_q[$];

   always #4 clk = ~clk;
   assign ts = TSW'(cyc);

   mpx_readout #(.MP(MP), .PIX_COLS(PC), .PIX_ROWS(PR), .TS_W(TSW)) u_mpx_readout (
      .clk(clk), .rst_n(rst_n), .hit_i(hit), .ts_i(ts), .out_ready_i(out_ready),
      .out_valid_o(out_valid), .out_col_o(out_col), .out_row_o(out_row),
      .out_ts_o(out_ts), .out_map_o(out_map));

   initial forever begin @(posedge clk); #1 cyc++; end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   function automatic int pix(input int y, input int x);
      return y * PC + x;
   endfunction

   // apply one cycle of hits; expected words follow from R2/R3
   task automatic pulse(input logic [NPIX-1:0] v, input bit expect_words);
      int maps[NCOL][NROW];
      @(posedge clk); #2;
      hit = v;
      for (int c = 0; c < NCOL; c++) for (int r = 0; r < NROW; r++) maps[c][r] = 0;
      for (int i = 0; i < NPIX; i++) if (v[i]) begin
         int y = i / PC, x = i % PC;
         maps[x/MP][y/MP] |= 1 << ((y % MP) * MP + (x % MP));
      end
      if (expect_words)
         for (int c = 0; c < NCOL; c++) for (int r = 0; r < NROW; r++)
            if (maps[c][r] != 0)
               exp_q.push_back('{c, r, (cyc + 1) % (1 << TSW), maps[c][r]});
      @(posedge clk); #2;
      hit = '0;
   endtask

   task automatic drain(input string req);
      int n = 0;
      while (exp_q.size() != 0 && n < 3000) begin @(posedge clk); n++; end
      repeat (20) @(posedge clk);
      chk(exp_q.size() == 0, req, "words still missing", exp_q.size(), 0);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         int k;
         k = -1;
         got_q.push_back('{int'(out_col), int'(out_row), int'(out_ts), int'(out_map)});
         for (int i = 0; i < exp_q.size(); i++)
            if (k < 0 && exp_q[i].c == int'(out_col) && exp_q[i].r == int'(out_row)) k = i;
         chk(k >= 0, "R4", "unexpected word at col*16+row", int'(out_col)*16 + int'(out_row), -1);
         if (k >= 0) begin
            chk(int'(out_ts) == exp_q[k].ts, "R3", "timestamp", int'(out_ts), exp_q[k].ts);
            chk(int'(out_map) == exp_q[k].map, "R2", "bitmap", int'(out_map), exp_q[k].map);
            exp_q.delete(k);
         end
      end
   end

   task automatic finish_sim();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      finish_sim();
   end

   initial begin
      logic [NPIX-1:0] v;
      logic [1:0] hc, hr; logic [TSW-1:0] hts; logic [MPB-1:0] hm;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R1: idle after reset
      repeat (10) @(negedge clk);
      chk(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);
      out_ready = 1'b1;

      // R2 R3: single pixel at row 3, col 5 -> mp (2,1), bit 3
      v = '0; v[pix(3, 5)] = 1'b1; pulse(v, 1); drain("R2");

      // R5: two pixels of one mp in the same cycle -> one word, map 1001
      v = '0; v[pix(0, 0)] = 1'b1; v[pix(1, 1)] = 1'b1; got_q.delete();
      pulse(v, 1); drain("R5");
      chk(got_q.size() == 1, "R5", "word count", got_q.size(), 1);

      // R4 R8: freeze under backpressure
      #2 out_ready = 1'b0;
      v = '0; v[pix(0, 2)] = 1'b1; pulse(v, 1);
      repeat (5) @(posedge clk);
      v = '0; v[pix(1, 3)] = 1'b1; pulse(v, 0);
      repeat (4) @(negedge clk);
      chk(out_valid == 1'b1, "R8", "stalled valid", out_valid, 1);
      hc = out_col; hr = out_row; hts = out_ts; hm = out_map;
      repeat (8) @(negedge clk);
      chk({hc, hr, hts, hm} == {out_col, out_row, out_ts, out_map}, "R8",
          "stalled word changed", int'(out_map), int'(hm));
      chk(int'(out_map) == 1, "R4", "map after late hit", int'(out_map), 1);
      @(posedge clk); #2 out_ready = 1'b1;
      drain("R4");

      // R6: col 3 rows 3,1,2 pending together -> ascending rows
      #2 out_ready = 1'b0; got_q.delete();
      v = '0; v[pix(6, 6)] = 1'b1; v[pix(2, 6)] = 1'b1; v[pix(4, 7)] = 1'b1;
      pulse(v, 1);
      repeat (12) @(posedge clk); #2 out_ready = 1'b1;
      drain("R6");
      chk(got_q.size() == 3, "R6", "word count", got_q.size(), 3);
      if (got_q.size() == 3) begin
         chk(got_q[0].r == 1, "R6", "first row", got_q[0].r, 1);
         chk(got_q[1].r == 2, "R6", "second row", got_q[1].r, 2);
         chk(got_q[2].r == 3, "R6", "third row", got_q[2].r, 3);
      end

      // R7: every column, mp rows 0 and 2
      got_q.delete(); v = '0;
      for (int c = 0; c < NCOL; c++) begin
         v[pix(0, c * MP)] = 1'b1; v[pix(4, c * MP + 1)] = 1'b1;
      end
      pulse(v, 1); drain("R7");
      chk(got_q.size() == 2 * NCOL, "R7", "word count", got_q.size(), 2 * NCOL);
      if (got_q.size() == 2 * NCOL)
         for (int i = 0; i < 2 * NCOL; i += 2) begin
            chk(got_q[i].c == got_q[i+1].c, "R7", "column split", got_q[i+1].c, got_q[i].c);
            if (i > 0)
               chk(got_q[i].c == (got_q[i-2].c + 1) % NCOL, "R7", "column step",
                   got_q[i].c, (got_q[i-2].c + 1) % NCOL);
         end

      // R8: bursty ready, six macropixels, each delivered once
      got_q.delete(); v = '0;
      for (int c = 0; c < 3; c++) begin
         v[pix(1, c * MP)] = 1'b1; v[pix(7, c * MP + 1)] = 1'b1;
      end
      pulse(v, 1);
      for (int i = 0; i < 80; i++) begin
         @(posedge clk); #2 out_ready = (i % 3 == 1);
      end
      out_ready = 1'b1;
      drain("R8");
      chk(got_q.size() == 6, "R8", "word count", got_q.size(), 6);

      // R3: timestamp wrap to zero
      got_q.delete();
      do begin @(posedge clk); #2; end while (cyc % 16 != 14);
      v = '0; v[pix(5, 2)] = 1'b1; pulse(v, 1); drain("R3");
      chk(got_q.size() == 1 && got_q[0].ts == 0, "R3", "wrapped stamp",
          got_q.size() > 0 ? got_q[0].ts : -1, 0);

      // R9: re-arm after transfer
      got_q.delete();
      v = '0; v[pix(2, 3)] = 1'b1; pulse(v, 1); drain("R9");
      repeat (3) @(posedge clk);
      v = '0; v[pix(3, 2)] = 1'b1; pulse(v, 1); drain("R9");
      chk(got_q.size() == 2, "R9", "word count", got_q.size(), 2);
      if (got_q.size() == 2)
         chk(got_q[1].map == 4'b0100, "R9", "second map", got_q[1].map, 4);

      finish_sim();
   end
endmodule